// File: doc/BRIEF.md
# IPv4 Transmit Header Framer

This block turns a buffered payload into a complete IPv4 datagram for a MAC. The host first fills an internal byte-wide transmit buffer through a simple write port. It then presents the payload length, the source and destination addresses, and the service, lifetime and protocol values, and pulses a send request. The block captures these fields and works out the header checksum. It then streams the 20-byte header and the payload to the MAC, one byte for each trigger strobe the MAC raises.

The header is always the minimal form: version 4 with a five-word header length, the don't-fragment flag set, and a zero fragment offset. No options are added and no fragmentation is done, so a payload larger than the buffer is refused at the request. The identification field starts at zero after reset and advances by one for each datagram that completes.

Top module: `ipv4_tx_framer`

## Requirements
- R1: After reset, `busy`, `tx_valid` and `tx_last` are low, and the first datagram carries identification 0.
- R2: A `send` pulse while idle, with `pay_len` at most the buffer depth (2^ADDR_W bytes), is accepted: `busy` is high in the next cycle.
- R3: A `send` with `pay_len` above the buffer depth is refused: `busy` stays low and no byte is produced.
- R4: A `send` while `busy` is high is ignored. The datagram in progress continues unchanged.
- R5: Each output byte appears with `tx_valid` high for one cycle, in the cycle after a `strobe` sampled while sending. With no strobe, or while idle or computing the checksum, no byte is produced.
- R6: Header bytes in order are: 0x45, ToS, total length (payload+20, high byte first), identification (high first), 0x40, 0x00, TTL, protocol, checksum (high first), source address (4 bytes, MSB first), destination address (4 bytes, MSB first).
- R7: The checksum is the inverted 16-bit value of the ones'-complement sum of the nine other header words, with carries folded back. It is ready before the first header byte is sent.
- R8: Payload byte k, written to buffer address k, is sent as datagram byte 20+k, for k from 0 to `pay_len`-1. A zero length gives a header-only datagram.
- R9: `tx_last` is high together with `tx_valid` on the final byte only, and `busy` is low from that same cycle.
- R10: The identification increases by one after each completed datagram and is unchanged by refused requests.
- R11: Buffer writes while `busy` is high are ignored and do not alter the payload of any later datagram.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Buffer write strobe from host |
| wr_addr | input | ADDR_W | Buffer write address |
| wr_data | input | 8 | Buffer write byte |
| pay_len | input | 16 | Payload length in bytes, sampled with send |
| dst_addr | input | 32 | Destination address |
| src_addr | input | 32 | Source address |
| tos | input | 8 | Type of service byte |
| ttl | input | 8 | Time to live |
| proto | input | 8 | Upper-layer protocol number |
| send | input | 1 | Start request |
| strobe | input | 1 | MAC trigger: move one byte |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | Byte valid, one cycle per strobe |
| tx_last | output | 1 | Final byte of datagram |
| busy | output | 1 | Datagram being prepared or sent |

## Verification
The assertions assume the MAC raises `strobe` only as a single-cycle pulse or a train of them. They also assume the host holds `send` for one cycle and keeps the header fields stable around it. The bench drives every input from the falling edge. It pulses `send` for exactly one cycle. It issues strobes back to back or with idle gaps, some of which fall into the checksum cycles and must be ignored. Requests and buffer writes made during a transfer are deliberately illegal for the host, and the bench makes them only to show they are dropped.

// File: rtl/ipv4_tx_pkg.sv
package ipv4_tx_pkg;
   localparam int HDR_BYTES = 20;
   localparam logic [7:0] VER_IHL   = 8'h45;
   localparam logic [7:0] FLAG_DF_B = 8'h40;

   typedef enum logic [1:0] {ST_IDLE, ST_CALC, ST_SEND} tx_state_t;

   typedef struct packed {
      logic [7:0]  tos;
      logic [15:0] total_len;
      logic [15:0] ident;
      logic [7:0]  ttl;
      logic [7:0]  proto;
      logic [31:0] src;
      logic [31:0] dst;
   } hdr_fields_t;
endpackage

// File: rtl/ipv4_tx_ram.sv
module ipv4_tx_ram #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [7:0]        wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [7:0]        rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/ipv4_tx_csum.sv
module ipv4_tx_csum
   import ipv4_tx_pkg::*;
#(
   parameter int PIPE = 0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  hdr_fields_t fields,
   output logic [15:0] csum,
   output logic        ready
);
   logic [19:0] raw_sum;

   function automatic logic [15:0] fold_inv(input logic [19:0] s);
      logic [16:0] s1;
      logic [15:0] s2;
      s1 = 17'(s[15:0]) + 17'(s[19:16]);
      s2 = s1[15:0] + 16'(s1[16]);
      return ~s2;
   endfunction

   always_comb begin
      raw_sum = 20'({VER_IHL, fields.tos})
              + 20'(fields.total_len)
              + 20'(fields.ident)
              + 20'({FLAG_DF_B, 8'h00})
              + 20'({fields.ttl, fields.proto})
              + 20'(fields.src[31:16]) + 20'(fields.src[15:0])
              + 20'(fields.dst[31:16]) + 20'(fields.dst[15:0]);
   end

   generate
      if (PIPE == 0) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               csum  <= '0;
               ready <= 1'b0;
            end else begin
               ready <= start;
               if (start) csum <= fold_inv(raw_sum);
            end
         end
      end else begin : g_two_stage
         logic [19:0] sum_q;
         logic        sum_v;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sum_q <= '0;
               sum_v <= 1'b0;
               csum  <= '0;
               ready <= 1'b0;
            end else begin
               sum_v <= start;
               if (start) sum_q <= raw_sum;
               ready <= sum_v;
               if (sum_v) csum <= fold_inv(sum_q);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/ipv4_tx_hdr.sv
module ipv4_tx_hdr
   import ipv4_tx_pkg::*;
(
   input  logic [4:0]  sel,
   input  hdr_fields_t fields,
   input  logic [15:0] csum,
   output logic [7:0]  hbyte
);
   always_comb begin
      unique case (sel)
         5'd0:    hbyte = VER_IHL;
         5'd1:    hbyte = fields.tos;
         5'd2:    hbyte = fields.total_len[15:8];
         5'd3:    hbyte = fields.total_len[7:0];
         5'd4:    hbyte = fields.ident[15:8];
         5'd5:    hbyte = fields.ident[7:0];
         5'd6:    hbyte = FLAG_DF_B;
         5'd7:    hbyte = 8'h00;
         5'd8:    hbyte = fields.ttl;
         5'd9:    hbyte = fields.proto;
         5'd10:   hbyte = csum[15:8];
         5'd11:   hbyte = csum[7:0];
         5'd12:   hbyte = fields.src[31:24];
         5'd13:   hbyte = fields.src[23:16];
         5'd14:   hbyte = fields.src[15:8];
         5'd15:   hbyte = fields.src[7:0];
         5'd16:   hbyte = fields.dst[31:24];
         5'd17:   hbyte = fields.dst[23:16];
         5'd18:   hbyte = fields.dst[15:8];
         5'd19:   hbyte = fields.dst[7:0];
         default: hbyte = 8'h00;
      endcase
   end
endmodule

// File: rtl/ipv4_tx_framer.sv
module ipv4_tx_framer
   import ipv4_tx_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int CSUM_PIPE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [15:0]       pay_len,
   input  logic [31:0]       dst_addr,
   input  logic [31:0]       src_addr,
   input  logic [7:0]        tos,
   input  logic [7:0]        ttl,
   input  logic [7:0]        proto,
   input  logic              send,
   input  logic              strobe,
   output logic [7:0]        tx_data,
   output logic              tx_valid,
   output logic              tx_last,
   output logic              busy
);
   localparam int          DEPTH     = 1 << ADDR_W;
   localparam logic [16:0] DEPTH_EXT = 17'(DEPTH);
   localparam logic [15:0] HDR_LEN   = 16'(HDR_BYTES);

   generate
      if (ADDR_W < 1 || ADDR_W > 15) begin : g_bad_addr_w
         $error("ipv4_tx_framer: ADDR_W must be within 1..15");
      end
      if (CSUM_PIPE != 0 && CSUM_PIPE != 1) begin : g_bad_pipe
         $error("ipv4_tx_framer: CSUM_PIPE must be 0 or 1");
      end
   endgenerate

   tx_state_t   state;
   hdr_fields_t fields_q;
   logic [15:0] ident_q;
   logic [15:0] idx;
   logic [15:0] last_idx;
   logic        csum_start;
   logic        csum_ready;
   logic [15:0] csum_val;
   logic [7:0]  hdr_byte;
   logic [7:0]  ram_byte;
   logic [ADDR_W-1:0] rd_addr;
   logic        accept;
   logic        ram_we;
   logic [7:0]  next_byte;

   assign accept   = (state == ST_IDLE) && send && ({1'b0, pay_len} <= DEPTH_EXT);
   assign ram_we   = wr_en && (state == ST_IDLE);
   assign last_idx = fields_q.total_len - 16'd1;
   assign rd_addr  = ADDR_W'(idx - HDR_LEN);
   assign next_byte = (idx < HDR_LEN) ? hdr_byte : ram_byte;
   assign busy     = (state != ST_IDLE);

   ipv4_tx_ram #(.ADDR_W(ADDR_W)) u_ram (
      .clk   (clk),
      .we    (ram_we),
      .waddr (wr_addr),
      .wdata (wr_data),
      .raddr (rd_addr),
      .rdata (ram_byte)
   );

   ipv4_tx_csum #(.PIPE(CSUM_PIPE)) u_csum (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (csum_start),
      .fields (fields_q),
      .csum   (csum_val),
      .ready  (csum_ready)
   );

   ipv4_tx_hdr u_hdr (
      .sel    (idx[4:0]),
      .fields (fields_q),
      .csum   (csum_val),
      .hbyte  (hdr_byte)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         fields_q   <= '0;
         ident_q    <= '0;
         idx        <= '0;
         csum_start <= 1'b0;
         tx_data    <= '0;
         tx_valid   <= 1'b0;
         tx_last    <= 1'b0;
      end else begin
         csum_start <= accept;
         tx_valid   <= 1'b0;
         tx_last    <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  fields_q.tos       <= tos;
                  fields_q.total_len <= pay_len + HDR_LEN;
                  fields_q.ident     <= ident_q;
                  fields_q.ttl       <= ttl;
                  fields_q.proto     <= proto;
                  fields_q.src       <= src_addr;
                  fields_q.dst       <= dst_addr;
                  idx                <= '0;
                  state              <= ST_CALC;
               end
            end
            ST_CALC: begin
               if (csum_ready) state <= ST_SEND;
            end
            ST_SEND: begin
               if (strobe) begin
                  tx_data  <= next_byte;
                  tx_valid <= 1'b1;
                  if (idx == last_idx) begin
                     tx_last <= 1'b1;
                     ident_q <= ident_q + 16'd1;
                     state   <= ST_IDLE;
                  end else begin
                     idx <= idx + 16'd1;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ipv4_tx_framer_chk.sv
module ipv4_tx_framer_chk #(
   parameter int ADDR_W = 8
) (
   input logic        clk,
   input logic        rst_n,
   input logic [15:0] pay_len,
   input logic        send,
   input logic        strobe,
   input logic [7:0]  tx_data,
   input logic        tx_valid,
   input logic        tx_last,
   input logic        busy
);
   localparam logic [16:0] DEPTH_EXT = 17'(1 << ADDR_W);

   logic [15:0] seen;

   always_ff @(posedge clk) begin
      if (!rst_n)                   seen <= '0;
      else if (tx_valid && tx_last) seen <= '0;
      else if (tx_valid)            seen <= seen + 16'd1;
   end

   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (send && !busy && ({1'b0, pay_len} <= DEPTH_EXT)) |=> busy);      // R2
   AST_REJECT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
      (send && !busy && ({1'b0, pay_len} > DEPTH_EXT)) |=> !busy);      // R3
   AST_BYTE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> ($past(strobe) && $past(busy)));                    // R5
   AST_FIRST_BYTE_VER: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && seen == 16'd0) |-> (tx_data == 8'h45));             // R6
   AST_LAST_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_last) |-> !busy);                                // R9
   AST_BUSY_UNTIL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (busy || (tx_valid && tx_last)));                       // R9
   AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last |-> tx_valid);                                           // R9
endmodule

bind ipv4_tx_framer ipv4_tx_framer_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pay_len  (pay_len),
   .send     (send),
   .strobe   (strobe),
   .tx_data  (tx_data),
   .tx_valid (tx_valid),
   .tx_last  (tx_last),
   .busy     (busy)
);

// File: tb/ipv4_tx_framer_bench.sv
module ipv4_tx_framer_bench;
   localparam int AW    = 4;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic [15:0]   pay_len = '0;
   logic [31:0]   dst_addr = '0;
   logic [31:0]   src_addr = '0;
   logic [7:0]    tos = '0;
   logic [7:0]    ttl = '0;
   logic [7:0]    proto = '0;
   logic          send = 1'b0;
   logic          strobe = 1'b0;
   logic [7:0]    tx_data;
   logic          tx_valid;
   logic          tx_last;
   logic          busy;

   int checks = 0;
   int fails  = 0;
   logic [15:0] ident_exp = 16'd0;
   logic [7:0]  mirror [DEPTH];
   logic [8:0]  exp_q [$];
   int          pos_q [$];
   logic        done = 1'b0;

   always #10 clk = ~clk;

   ipv4_tx_framer #(.ADDR_W(AW), .CSUM_PIPE(1)) u_ipv4_tx_framer (.*);

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && tx_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R3/R5 unexpected byte", int'(tx_data), -1);
         end else begin
            logic [8:0] e;
            int p;
            e = exp_q.pop_front();
            p = pos_q.pop_front();
            if (p == 10 || p == 11)
               chk(tx_data == e[7:0], "R7 checksum byte", int'(tx_data), int'(e[7:0]));
            else if (p < 20)
               chk(tx_data == e[7:0], "R6 header byte", int'(tx_data), int'(e[7:0]));
            else
               chk(tx_data == e[7:0], "R8 payload byte", int'(tx_data), int'(e[7:0]));
            chk(tx_last == e[8], "R9 last flag", int'(tx_last), int'(e[8]));
            if (tx_last) chk(!busy, "R9 busy low on last", int'(busy), 0);
         end
      end
   end

   task automatic load(input int n, input int seed);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         wr_en   = 1'b1;
         wr_addr = AW'(i);
         wr_data = 8'(i * 37 + seed);
         mirror[i] = 8'(i * 37 + seed);
      end
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic expect_frame(input int n);
      logic [7:0]  h [20];
      logic [15:0] tl;
      logic [19:0] s;
      logic [16:0] s1;
      logic [15:0] ck;
      int total;
      tl = 16'(n + 20);
      s = 20'({8'h45, tos}) + 20'(tl) + 20'(ident_exp) + 20'(16'h4000)
        + 20'({ttl, proto}) + 20'(src_addr[31:16]) + 20'(src_addr[15:0])
        + 20'(dst_addr[31:16]) + 20'(dst_addr[15:0]);
      s1 = 17'(s[15:0]) + 17'(s[19:16]);
      ck = ~(s1[15:0] + 16'(s1[16]));
      h = '{8'h45, tos, tl[15:8], tl[7:0], ident_exp[15:8], ident_exp[7:0],
            8'h40, 8'h00, ttl, proto, ck[15:8], ck[7:0],
            src_addr[31:24], src_addr[23:16], src_addr[15:8], src_addr[7:0],
            dst_addr[31:24], dst_addr[23:16], dst_addr[15:8], dst_addr[7:0]};
      total = n + 20;
      for (int i = 0; i < total; i++) begin
         logic [7:0] b;
         b = (i < 20) ? h[i] : mirror[i - 20];
         exp_q.push_back({(i == total - 1), b});
         pos_q.push_back(i);
      end
   endtask

   task automatic request(input int n, input logic [31:0] sa, input logic [31:0] da,
                          input logic [7:0] t, input logic [7:0] l, input logic [7:0] p);
      @(negedge clk);
      pay_len = 16'(n); src_addr = sa; dst_addr = da; tos = t; ttl = l; proto = p;
      send = 1'b1;
      @(negedge clk);
      send = 1'b0;
   endtask

   task automatic pump(input int gap);
      while (busy) begin
         strobe = 1'b1;
         @(negedge clk);
         strobe = 1'b0;
         repeat (gap) @(negedge clk);
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic frame(input int n, input int gap, input logic [31:0] sa,
                        input logic [31:0] da, input logic [7:0] t,
                        input logic [7:0] l, input logic [7:0] p, input string tag);
      expect_frame_fields(n, sa, da, t, l, p);
      request(n, sa, da, t, l, p);
      chk(busy, {tag, " R2 busy after send"}, int'(busy), 1);
      pump(gap);
      chk(exp_q.size() == 0, {tag, " R8 all bytes sent"}, exp_q.size(), 0);
      ident_exp++;
   endtask

   task automatic expect_frame_fields(input int n, input logic [31:0] sa,
                                      input logic [31:0] da, input logic [7:0] t,
                                      input logic [7:0] l, input logic [7:0] p);
      src_addr = sa; dst_addr = da; tos = t; ttl = l; proto = p;
      expect_frame(n);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!busy && !tx_valid && !tx_last, "R1 reset outputs", int'({busy, tx_valid, tx_last}), 0);

      // R2 R6 R7 R8 R9 R1: first frame, back-to-back strobes, ident 0
      load(4, 3);
      frame(4, 0, 32'hC0A8_0001, 32'h0A00_00FE, 8'h10, 8'd64, 8'd17, "f1");

      // R10: header-only frame with gapped strobes, ident 1
      frame(0, 2, 32'hFFFF_FFFF, 32'h8000_0001, 8'hB8, 8'd1, 8'd6, "f2");

      // R3: oversize request refused, ident unchanged
      request(DEPTH + 1, 32'h1, 32'h2, 8'h0, 8'd9, 8'd1);
      chk(!busy, "R3 oversize refused", int'(busy), 0);
      repeat (3) begin
         strobe = 1'b1; @(negedge clk); strobe = 1'b0; @(negedge clk);
      end
      chk(!busy, "R3 still idle", int'(busy), 0);

      // R5: strobes while idle produce nothing (monitor flags any byte)
      chk(exp_q.size() == 0, "R5 idle strobes silent", exp_q.size(), 0);

      // boundary: full buffer, ident must be 2 (R10)
      load(DEPTH, 91);
      frame(DEPTH, 1, 32'h0102_0304, 32'h0506_0708, 8'h00, 8'd255, 8'd1, "f3");

      // R4 R11: request and write during transfer are ignored
      load(5, 200);
      expect_frame_fields(5, 32'hAABB_CCDD, 32'h1122_3344, 8'h20, 8'd32, 8'd17);
      request(5, 32'hAABB_CCDD, 32'h1122_3344, 8'h20, 8'd32, 8'd17);
      repeat (8) begin
         strobe = 1'b1; @(negedge clk); strobe = 1'b0;
      end
      send = 1'b1; pay_len = 16'd2; tos = 8'hFF; ttl = 8'd5;
      wr_en = 1'b1; wr_addr = '0; wr_data = 8'hEE;
      @(negedge clk);
      send = 1'b0; wr_en = 1'b0;
      tos = 8'h20; ttl = 8'd32;
      pump(0);
      chk(exp_q.size() == 0, "R4 frame completed unchanged", exp_q.size(), 0);
      ident_exp++;

      // R11: buffer untouched by the write made while busy
      frame(5, 0, 32'h0, 32'h0, 8'h00, 8'd8, 8'd2, "f5 R11");

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule